// File: doc/BRIEF.md
# Cheat-Code Read Patch Unit

This unit sits on the read data path between the system bus and the cartridge. Software or a front panel feeds it cheat codes one letter per cycle. Each code uses a 16-letter alphabet and is 6 or 8 letters long. When the commit strobe arrives, the unit unscrambles the letters into three fields: a target address, a replacement byte and, for 8-letter codes only, a compare byte. It then stores the result in a small table.

On every read in cartridge space, the unit looks the address up in the table. A 6-letter entry always replaces the cartridge byte. An 8-letter entry replaces it only when the original byte equals the stored compare value. The byte that leaves the unit is also captured in an open-bus latch. A clear command or reset empties the table.

Top module: `cheat_patch`

## Requirements
- R1: After reset the table is empty, `err`, `full` and `open_bus` read 0, and every read passes `cart_data` through unchanged.
- R2: The letters A,P,Z,L,G,I,T,Y,E,O,X,U,K,S,V,N (uppercase ASCII) carry nibble values 0 through 15 in that order. A commit of a code that holds any other character sets `err` and leaves the table unchanged.
- R3: A commit whose letter count is neither 6 nor 8 sets `err` and leaves the table unchanged. A commit that is accepted clears `err`. Letters presented in the same cycle as `commit` are dropped, and every commit empties the letter buffer.
- R4: With n0..n7 the letter nibbles in entry order, the target address is 0x8000 OR the following fields: {n3[2:0]} at bits 14:12, n4[3] at bit 11, n5[2:0] at bits 10:8, n1[3] at bit 7, n2[2:0] at bits 6:4, n3[3] at bit 3, and n4[2:0] at bits 2:0.
- R5: For a 6-letter code, the replacement byte is n0[3] at bit 7, n1[2:0] at bits 6:4, n5[3] at bit 3 and n0[2:0] at bits 2:0. A matching read returns this byte no matter what the cartridge byte is.
- R6: For an 8-letter code, bit 3 of the replacement byte is taken from n7[3] instead. The compare byte is n6[3] at bit 7, n7[2:0] at bits 6:4, n5[3] at bit 3 and n6[2:0] at bits 2:0. A matching read returns the replacement byte only when `cart_data` equals the compare byte; otherwise it returns `cart_data`.
- R7: Reads at addresses below 0x4020 are never patched.
- R8: Committing a code whose address is already in the table replaces that entry. This succeeds even when the table is full.
- R9: The table holds ENTRIES (default 8) codes. A commit of a new address into a full table is dropped and sets `full`. The next commit clears `full`, and so does `clear_all`.
- R10: On a cycle with `rd_en` high, `open_bus` captures the value driven on `bus_data`, which is the patched value, and holds it otherwise.
- R11: `clear_all` empties the whole table by the next cycle. It takes priority over a commit in the same cycle, and that commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_valid | input | 1 | Letter strobe |
| chr_in | input | 8 | ASCII letter |
| commit | input | 1 | Decode buffered letters and store |
| clear_all | input | 1 | Invalidate all entries |
| rd_en | input | 1 | Bus read cycle, loads open-bus latch |
| rd_addr | input | 16 | Read address |
| cart_data | input | 8 | Byte from cartridge |
| bus_data | output | 8 | Possibly patched byte to bus |
| open_bus | output | 8 | Last byte presented on a read |
| err | output | 1 | Last commit rejected |
| full | output | 1 | Last commit dropped, table full |

## Verification
The assertions check four things on every cycle: low addresses pass through untouched, `clear_all` empties the table by the next cycle, the open-bus latch follows the patched output, and a rejected length leaves the table unchanged. They also check that `full` is never set unless every slot is occupied and that a commit always empties the letter buffer.

Only the bench's scenarios can show the rest. These are the exact bit permutation of the address and data fields, the compare gating of 8-letter codes, overwriting by address, and dropping a ninth distinct code. The bench checks them against its own decoder for both directed and random codes.

// File: rtl/cheat_patch.sv
module cheat_patch #(
  parameter int ENTRIES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chr_valid,
  input  logic [7:0] chr_in,
  input  logic       commit,
  input  logic       clear_all,
  input  logic       rd_en,
  input  logic [15:0] rd_addr,
  input  logic [7:0] cart_data,
  output logic [7:0] bus_data,
  output logic [7:0] open_bus,
  output logic       err,
  output logic       full
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [3:0] nib [8];
  logic [3:0] cnt;
  logic       bad;

  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] t_hascmp;
  logic [15:0] t_addr [ENTRIES];
  logic [7:0]  t_data [ENTRIES];
  logic [7:0]  t_cmp  [ENTRIES];

  function automatic logic [4:0] letter(input logic [7:0] c);
    case (c)
      "A": letter = 5'h10; "P": letter = 5'h11; "Z": letter = 5'h12; "L": letter = 5'h13;
      "G": letter = 5'h14; "I": letter = 5'h15; "T": letter = 5'h16; "Y": letter = 5'h17;
      "E": letter = 5'h18; "O": letter = 5'h19; "X": letter = 5'h1A; "U": letter = 5'h1B;
      "K": letter = 5'h1C; "S": letter = 5'h1D; "V": letter = 5'h1E; "N": letter = 5'h1F;
      default: letter = 5'h00;
    endcase
  endfunction

  logic [4:0] lk;
  assign lk = letter(chr_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (commit) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (chr_valid) begin
      if (cnt != 4'hF) cnt <= cnt + 4'd1;
      if (!lk[4]) bad <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (chr_valid && !commit && cnt < 4'd8) nib[cnt[2:0]] <= lk[3:0];
  end

  logic        is8, len_ok, code_ok;
  logic [15:0] dec_addr;
  logic [7:0]  dec_data, dec_cmp;
  logic [3:0]  last;

  assign is8     = (cnt == 4'd8);
  assign len_ok  = (cnt == 4'd6) || is8;
  assign code_ok = len_ok && !bad;
  assign last    = is8 ? nib[7] : nib[5];
  assign dec_addr = 16'h8000 | {1'b0, nib[3][2:0], nib[4][3], nib[5][2:0],
                                nib[1][3], nib[2][2:0], nib[3][3], nib[4][2:0]};
  assign dec_data = {nib[0][3], nib[1][2:0], last[3], nib[0][2:0]};
  assign dec_cmp  = {nib[6][3], nib[7][2:0], nib[5][3], nib[6][2:0]};

  logic             sel_ok;
  logic [IDX_W-1:0] sel;

  always_comb begin
    sel_ok = 1'b0;
    sel    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) begin
        sel_ok = 1'b1;
        sel    = IDX_W'(i);
      end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (valid[i] && t_addr[i] == dec_addr) begin
        sel_ok = 1'b1;
        sel    = IDX_W'(i);
      end
  end

  logic do_store;
  assign do_store = commit && !clear_all && code_ok && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      err   <= 1'b0;
      full  <= 1'b0;
    end else if (clear_all) begin
      valid <= '0;
      full  <= 1'b0;
    end else if (commit) begin
      err  <= !code_ok;
      full <= code_ok && !sel_ok;
      if (do_store) valid[sel] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_store) begin
      t_addr[sel]   <= dec_addr;
      t_data[sel]   <= dec_data;
      t_cmp[sel]    <= dec_cmp;
      t_hascmp[sel] <= is8;
    end
  end

  logic       patch;
  logic [7:0] pval;

  always_comb begin
    patch = 1'b0;
    pval  = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid[i] && t_addr[i] == rd_addr && (!t_hascmp[i] || t_cmp[i] == cart_data)) begin
        patch = 1'b1;
        pval  = t_data[i];
      end
  end

  assign bus_data = (rd_addr >= 16'h4020 && patch) ? pval : cart_data;

  always_ff @(posedge clk) begin
    if (!rst_n) open_bus <= '0;
    else if (rd_en) open_bus <= bus_data;
  end
endmodule

module cheat_patch_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               commit,
  input logic               clear_all,
  input logic               rd_en,
  input logic [15:0]        rd_addr,
  input logic [7:0]         cart_data,
  input logic [7:0]         bus_data,
  input logic [7:0]         open_bus,
  input logic               err,
  input logic               full,
  input logic [ENTRIES-1:0] valid,
  input logic [3:0]         cnt
);
  a_r7_low_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr < 16'h4020 |-> bus_data == cart_data);

  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> valid == '0);

  a_r10_latch_patched: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> open_bus == $past(bus_data));

  a_r3_bad_length: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clear_all && cnt != 4'd6 && cnt != 4'd8 |=> err && $stable(valid));

  a_r9_full_only_when_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> &valid);

  a_r3_buffer_empties: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cnt == 4'd0);
endmodule

bind cheat_patch cheat_patch_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .clear_all(clear_all), .rd_en(rd_en),
  .rd_addr(rd_addr), .cart_data(cart_data), .bus_data(bus_data), .open_bus(open_bus),
  .err(err), .full(full), .valid(valid), .cnt(cnt)
);

// File: tb/cheat_patch_test.sv
module cheat_patch_test;
  logic clk = 0, rst_n = 0;
  logic chr_valid = 0, commit = 0, clear_all = 0, rd_en = 0;
  logic [7:0] chr_in = 0, cart_data = 0;
  logic [15:0] rd_addr = 0;
  logic [7:0] bus_data, open_bus;
  logic err, full;

  always #10 clk = ~clk;

  cheat_patch uut (.*);

  localparam string ALPHA = "APZLGITYEOXUKSVN";
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_addr [8];
  logic [7:0]  m_data [8], m_cmp [8];
  bit          m_has [8], m_val [8];
  bit          m_err, m_full;
  logic [15:0] l_addr;
  logic [7:0]  l_data, l_cmp;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nib_of(byte c);
    for (int k = 0; k < 16; k++) if (ALPHA[k] == c) return k;
    return -1;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a, logic [7:0] cart);
    if (a < 16'h4020) return cart;
    for (int k = 0; k < 8; k++)
      if (m_val[k] && m_addr[k] == a && (!m_has[k] || m_cmp[k] == cart)) return m_data[k];
    return cart;
  endfunction

  task automatic model_commit(string s);
    int n [8];
    bit bad;
    int idx;
    bad = !(s.len() == 6 || s.len() == 8);
    for (int k = 0; k < s.len() && k < 8; k++) begin
      n[k] = nib_of(s[k]);
      if (n[k] < 0) bad = 1;
    end
    m_err = bad;
    m_full = 0;
    if (bad) return;
    l_addr = 16'h8000 + 16'(((n[3] & 7) << 12) | ((n[5] & 7) << 8) | ((n[4] & 8) << 8) |
             ((n[2] & 7) << 4) | ((n[1] & 8) << 4) | (n[4] & 7) | (n[3] & 8));
    l_data = 8'(((n[1] & 7) << 4) | ((n[0] & 8) << 4) | (n[0] & 7) |
             ((s.len() == 8 ? n[7] : n[5]) & 8));
    l_cmp = (s.len() == 8) ? 8'(((n[7] & 7) << 4) | ((n[6] & 8) << 4) | (n[6] & 7) | (n[5] & 8)) : 8'h00;
    idx = -1;
    for (int k = 7; k >= 0; k--) if (!m_val[k]) idx = k;
    for (int k = 7; k >= 0; k--) if (m_val[k] && m_addr[k] == l_addr) idx = k;
    if (idx < 0) begin
      m_full = 1;
      return;
    end
    m_val[idx] = 1; m_addr[idx] = l_addr; m_data[idx] = l_data;
    m_cmp[idx] = l_cmp; m_has[idx] = (s.len() == 8);
  endtask

  task automatic send(string s, string req);
    for (int k = 0; k < s.len(); k++) begin
      @(negedge clk); chr_valid = 1; chr_in = s[k];
    end
    @(negedge clk); chr_valid = 0; commit = 1;
    @(negedge clk); commit = 0;
    model_commit(s);
    #2;
    check({req, " err"}, err, m_err);
    check({req, " full"}, full, m_full);
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] c, string req);
    logic [7:0] e;
    @(negedge clk); rd_addr = a; cart_data = c; rd_en = 1;
    e = exp_read(a, c);
    #2;
    check(req, bus_data, e);
    @(negedge clk); rd_en = 0;
    #2;
    check("R10 open_bus", open_bus, e);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_all = 1;
    @(negedge clk); clear_all = 0;
    for (int k = 0; k < 8; k++) m_val[k] = 0;
    m_full = 0;
  endtask

  function automatic string rand_code(int len);
    string s = "";
    for (int k = 0; k < len; k++) begin
      int j = $urandom % 16;
      s = {s, ALPHA.substr(j, j)};
    end
    return s;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < 8; k++) m_val[k] = 0;
    m_err = 0; m_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check("R1 err", err, 0);
    check("R1 full", full, 0);
    check("R1 open_bus", open_bus, 0);
    @(negedge clk); rd_addr = 16'h8000; cart_data = 8'h5A; #2;
    check("R1 passthru", bus_data, 8'h5A);

    send("SXIOPO", "R4 R5 six");
    rd(l_addr, 8'h00, "R5 patch");
    rd(l_addr, 8'hFF, "R5 patch any");
    check("R4 addr hand", l_addr, 16'h91D9);
    check("R5 data hand", l_data, 8'hAD);
    rd(16'h0123, 8'h77, "R7 low passthru");
    rd(16'h401F, 8'h31, "R7 edge passthru");

    send("AAAAAAA", "R3 len7");
    send("AAAA", "R3 len4");
    send("AAAAAB", "R2 bad char");
    rd(16'h8000, 8'h42, "R2 table unchanged");
    rd(16'h91D9, 8'h10, "R3 table unchanged");

    send("GAKOLIZT", "R6 eight");
    rd(l_addr, l_cmp, "R6 compare hit");
    rd(l_addr, l_cmp ^ 8'h01, "R6 compare miss");

    send("SXIOPO", "R8 first");
    send("AXIOPO", "R8 overwrite");
    rd(l_addr, 8'h99, "R8 new data");

    do_clear();
    rd(16'h91D9, 8'h21, "R11 cleared");
    for (int k = 0; k < 8; k++) send({"AAAA", ALPHA.substr(k, k), "A"}, "R9 fill");
    send("AAAAEA", "R9 ninth");
    check("R9 full set", full, 1);
    rd(l_addr, 8'h3C, "R9 dropped");
    send("PAAAAA", "R8 overwrite when full");
    check("R9 full cleared", full, 0);
    rd(16'h8000, 8'h00, "R8 full overwrite data");

    for (int it = 0; it < 300; it++) begin
      if ($urandom % 20 == 0) do_clear();
      send(rand_code(($urandom % 2) ? 8 : 6), "R4 R5 R6 random");
      for (int r = 0; r < 3; r++) begin
        int k = $urandom % 8;
        logic [7:0] c = $urandom;
        if (m_val[k]) begin
          if (m_has[k] && ($urandom % 2)) c = m_cmp[k];
          rd(m_addr[k], c, "R6 random read");
        end else begin
          rd(16'($urandom), c, "R7 random read");
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule